// File: doc/BRIEF.md
# Counter-Sequenced Serial Transmitter

This block turns bytes written over a narrow parallel write port into asynchronous serial characters. A host puts a byte on the data bus and pulses chip select together with write while the empty flag is high. The byte is captured in a holding register, the empty flag drops, and the serial line then carries one character. The character is a low start bit, the eight data bits starting with the least significant, and a high stop bit. When the stop bit ends, the empty flag rises again and the host may write the next byte.

All timing comes from a single 6-bit sequencing counter, with no separate baud-rate divider. The lower two bits count the four clocks inside one serial bit. The upper four bits name the bit being sent: value 7 is the start bit, values 8 to 15 are data bits 0 to 7, and the wrap to 0 is the stop bit. The serial bit rate is therefore a quarter of the clock rate. Between characters the counter is parked at 28 (index 7, phase 0), and the line rests high.

Top module: `uart_seq_tx`

## Requirements
- R1: While reset is asserted and after it is released, with no write, `txd` is 1 and `tx_empty` is 1.
- R2: While no byte is pending, the sequencing counter holds at 28 (index 7, phase 0) and `txd` stays 1 for any number of cycles.
- R3: A rising clock edge with `wr_cs`=1, `wr_en`=1 and `tx_empty`=1 captures `wr_data`, and `tx_empty` is 0 after that edge.
- R4: For the four cycles after the accepting edge (cycles 0 to 3, counted from that edge), `txd` is 0 (start bit).
- R5: In cycles 4+4k to 7+4k after the accepting edge, `txd` equals bit k of the captured byte, for k = 0 to 7 (least significant bit first).
- R6: In cycles 36 to 39 after the accepting edge, `txd` is 1 (stop bit).
- R7: `tx_empty` returns to 1 exactly 40 cycles after the accepting edge. The counter is then back at 28, and a later write starts a new character.
- R8: A write made while `tx_empty` is 0 is ignored: the character in progress keeps its data and timing, and no extra character follows it.
- R9: `wr_cs` without `wr_en`, or `wr_en` without `wr_cs`, loads nothing: `tx_empty` and `txd` stay 1.
- R10: While a character is in progress, the counter rises by exactly one on every clock, and it wraps from 63 to 0 to enter the stop bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one serial bit lasts four periods |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_data | input | 8 | Byte to transmit |
| wr_cs | input | 1 | Chip select for the write port |
| wr_en | input | 1 | Write strobe, effective only together with `wr_cs` |
| txd | output | 1 | Serial output line, high at rest |
| tx_empty | output | 1 | High when a new byte may be written |

## Verification
A wrong counter value shows at once on `txd`, because the bit index selects the line value in every cycle. A wrong start, data or stop slot therefore appears within one four-cycle bit period of where it should be, and a counter that fails to wrap or park shifts `tx_empty` away from cycle 40. All 256 byte values are sent and compared cycle by cycle over the whole 40-cycle frame, so a swapped or stuck data bit shows up in the first byte that exercises it. An ignored write that leaks into the holding register changes the data bits that follow it in the same frame.

// File: rtl/uart_seq_pkg.sv
package uart_seq_pkg;
  localparam int DATA_W_DEF  = 8;
  localparam int PHASE_W_DEF = 2;
  localparam int INDEX_W_DEF = 4;

  // index of the start bit: data bits occupy the top DATA_W indices
  function automatic int start_index(input int index_w, input int data_w);
    return (1 << index_w) - data_w - 1;
  endfunction
endpackage

// File: rtl/uart_seq_counter.sv
module uart_seq_counter
  import uart_seq_pkg::*;
#(
  parameter int DATA_W  = DATA_W_DEF,
  parameter int PHASE_W = PHASE_W_DEF,
  parameter int INDEX_W = INDEX_W_DEF,
  localparam int CNT_W  = INDEX_W + PHASE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             frame_done
);
  localparam int START_IDX = start_index(INDEX_W, DATA_W);
  localparam logic [CNT_W-1:0] PARK_CNT = CNT_W'(START_IDX << PHASE_W);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'((1 << PHASE_W) - 1);

  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;

  assign frame_done = run && (cnt == LAST_CNT);
  assign cnt_en     = run;

  always_comb begin
    cnt_nxt = cnt;
    if (frame_done) cnt_nxt = PARK_CNT;
    else            cnt_nxt = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= PARK_CNT;
    else if (cnt_en) cnt <= cnt_nxt;
  end

  // R2
  park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> cnt == PARK_CNT);
  // R10
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !frame_done) |=> cnt == $past(cnt) + CNT_W'(1));
endmodule

// File: rtl/uart_seq_holdreg.sv
module uart_seq_holdreg
  import uart_seq_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cs,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              frame_done,
  output logic [DATA_W-1:0] hold_data,
  output logic              busy
);
  logic accept;
  logic busy_nxt;

  assign accept = wr_cs && wr_en && !busy;

  always_comb begin
    busy_nxt = busy;
    if (accept)          busy_nxt = 1'b1;
    else if (frame_done) busy_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= busy_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_data <= '0;
    else if (accept) hold_data <= wr_data;
  end

  // R3
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cs && wr_en && !busy) |=> busy && hold_data == $past(wr_data));
  // R8
  ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(hold_data));
endmodule

// File: rtl/uart_seq_bitsel.sv
module uart_seq_bitsel
  import uart_seq_pkg::*;
#(
  parameter int DATA_W  = DATA_W_DEF,
  parameter int PHASE_W = PHASE_W_DEF,
  parameter int INDEX_W = INDEX_W_DEF,
  localparam int CNT_W  = INDEX_W + PHASE_W
) (
  input  logic [CNT_W-1:0]  cnt,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              busy,
  output logic              line
);
  localparam int START_IDX = start_index(INDEX_W, DATA_W);

  logic [INDEX_W-1:0] idx;
  logic [PHASE_W-1:0] phase_unused;

  assign {idx, phase_unused} = cnt;

  always_comb begin
    line = 1'b1;
    if (busy) begin
      if (idx == INDEX_W'(START_IDX)) line = 1'b0;
      for (int k = 0; k < DATA_W; k++) begin
        if (idx == INDEX_W'(START_IDX + 1 + k)) line = hold_data[k];
      end
    end
  end
endmodule

// File: rtl/uart_seq_tx.sv
module uart_seq_tx
  import uart_seq_pkg::*;
#(
  parameter int DATA_W  = DATA_W_DEF,
  parameter int PHASE_W = PHASE_W_DEF,
  parameter int INDEX_W = INDEX_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_cs,
  input  logic              wr_en,
  output logic              txd,
  output logic              tx_empty
);
  localparam int CNT_W = INDEX_W + PHASE_W;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [CNT_W-1:0]  cnt;
  logic              frame_done;
  logic              busy;
  logic [DATA_W-1:0] hold_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  uart_seq_holdreg #(.DATA_W(DATA_W)) i_holdreg (
    .clk(clk), .rst_n(rst_sync_n), .wr_cs(wr_cs), .wr_en(wr_en),
    .wr_data(wr_data), .frame_done(frame_done),
    .hold_data(hold_data), .busy(busy)
  );

  uart_seq_counter #(.DATA_W(DATA_W), .PHASE_W(PHASE_W), .INDEX_W(INDEX_W)) i_counter (
    .clk(clk), .rst_n(rst_sync_n), .run(busy), .cnt(cnt), .frame_done(frame_done)
  );

  uart_seq_bitsel #(.DATA_W(DATA_W), .PHASE_W(PHASE_W), .INDEX_W(INDEX_W)) i_bitsel (
    .cnt(cnt), .hold_data(hold_data), .busy(busy), .line(txd)
  );

  assign tx_empty = !busy;

  // R1
  rest_line_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_empty |-> txd);
  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_done |=> tx_empty);
  // R6
  stop_slot_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && cnt < CNT_W'(1 << PHASE_W)) |-> txd);
endmodule

// File: tb/test_uart_seq_tx.sv
module test_uart_seq_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_cs = 1'b0;
  logic       wr_en = 1'b0;
  logic       txd;
  logic       tx_empty;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_seq_tx i_uart_seq_tx (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_cs(wr_cs),
    .wr_en(wr_en), .txd(txd), .tx_empty(tx_empty)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_line(input int n, input logic [7:0] b);
    if (n < 4)  return 1'b0;
    if (n < 36) return b[(n - 4) / 4];
    return 1'b1;
  endfunction

  // sends byte b; when poke is set a second write with junk is tried at cycle 10 and 39
  task automatic send(input logic [7:0] b, input bit poke, input logic [7:0] junk);
    @(negedge clk);
    wr_data = b; wr_cs = 1'b1; wr_en = 1'b1;
    @(posedge clk);
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      wr_cs = 1'b0; wr_en = 1'b0; wr_data = ~b;
      // R4 R5 R6
      check(n < 4 ? "R4 start" : (n < 36 ? "R5 data" : "R6 stop"), txd, exp_line(n, b));
      // R3
      check("R3 empty low during frame", tx_empty, 1'b0);
      if (poke && (n == 10 || n == 39)) begin
        wr_data = junk; wr_cs = 1'b1; wr_en = 1'b1;
      end
    end
    @(negedge clk);
    wr_cs = 1'b0; wr_en = 1'b0;
    // R7
    check("R7 empty back", tx_empty, 1'b1);
    check("R7 line rest", txd, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset line", txd, 1'b1);
    check("R1 reset empty", tx_empty, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release line", txd, 1'b1);
    check("R1 after release empty", tx_empty, 1'b1);
    // R2 idle hold
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R2 idle line", txd, 1'b1);
      check("R2 idle empty", tx_empty, 1'b1);
    end
    // R9 partial strobes
    wr_data = 8'h00; wr_cs = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    check("R9 cs only empty", tx_empty, 1'b1);
    check("R9 cs only line", txd, 1'b1);
    wr_cs = 1'b0; wr_en = 1'b1;
    @(negedge clk);
    check("R9 wr only empty", tx_empty, 1'b1);
    check("R9 wr only line", txd, 1'b1);
    wr_en = 1'b0;
    // R5 R10 exhaustive byte sweep
    for (int v = 0; v < 256; v++) send(8'(v), 1'b0, 8'h00);
    // R8 writes during a frame ignored
    send(8'hA5, 1'b1, 8'h5A);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check("R8 no extra frame line", txd, 1'b1);
      check("R8 no extra frame empty", tx_empty, 1'b1);
    end
    send(8'h0F, 1'b1, 8'hF0);
    // R7 back-to-back after release
    send(8'h81, 1'b0, 8'h00);
    send(8'h7E, 1'b0, 8'h00);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule